// File: doc/BRIEF.md
# Flag Offset Register Sequencer

This block holds the two thresholds used by a dual-clock FIFO's partial flags: the almost-empty offset `n` and the almost-full offset `m`. Each threshold is split into a byte-wide low register and a narrow high register, so there are four registers. They have no address. Software reaches them through a selection pointer that steps on every access and wraps around. Writes are taken on the write clock from the shared data input. Readback is launched on the read clock and returns words on the shared data output.

Whether load accesses are allowed is decided once, at reset. The load control is sampled while reset is held. If it is low, the load control later acts as the gate for offset accesses. If it is high, the block ignores every offset access until the next reset. The full offset is used by write-side logic and is published straight from the registers. The empty offset is used by read-side logic and crosses to the read clock as a whole word through a toggle request/acknowledge handshake. A read that coincides with a write is arbitrated in favour of the write, and the coincidence is recorded in a sticky error flag.

Top module: `flag_offset_seq`

## Requirements
- R1: After a reset both offsets are 7 (low register 7, high register 0), both selection pointers point at the empty-offset low register, `offRdValid` is 0 and `accessErr` is 0.
- R2: Each write-clock edge with `ldN`=0 and `wrEnN`=0 stores `dataIn` into the selected register and moves the write pointer one step. The order is empty-low (0), empty-high (1), full-low (2), full-high (3), and after full-high the pointer returns to empty-low.
- R3: Raising `ldN` does not move either pointer. The next load write after such a pause continues at the register that follows the last one written.
- R4: Each read-clock edge with `ldN`=0, `rdEnAN`=0 and `rdEnBN`=0 places the selected register on `offRdData` and moves the read pointer, which is separate from the write pointer, through the same wrapping order. A low register appears in bits 7:0 with bit 8 zero. A high register appears in bit 0 with all other bits zero.
- R5: An offset equals its high register times 256 plus its low register, giving 9 bits for a 512-deep FIFO. A low write keeps `dataIn[7:0]`, and a high write keeps only `dataIn[0]`.
- R6: A new empty offset reaches `emptyOffset` in the read-clock domain through the handshake within a bounded number of cycles. `emptyOffset` changes only when the handshake delivers a word, and always as the complete value.
- R7: `fullOffset` shows the updated full offset right after the write-clock edge that stores a full-offset register, and otherwise stays unchanged.
- R8: If `ldN` is high during reset, load writes and reads have no effect until the next reset: the offsets stay at 7, `offRdValid` stays 0 and `accessErr` stays 0.
- R9: When a load read and a load write happen on the same edge, the write takes effect, the read returns the value held before that write, and `accessErr` becomes 1 and stays 1 until reset.
- R10: `offRdValid` is 1 for exactly the read cycle after a load read. No read happens (no valid, pointer and `offRdData` unchanged) if either read enable is high or `ldN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Synchronous active-low reset, held over several edges of both clocks |
| ldN | input | 1 | Load control, active low; sampled during reset to choose load mode |
| wrEnN | input | 1 | Write enable, active low |
| rdEnAN | input | 1 | First read enable, active low |
| rdEnBN | input | 1 | Second read enable, active low |
| dataIn | input | 9 | Shared data input |
| emptyOffset | output | 9 | Almost-empty offset n, read-clock domain |
| fullOffset | output | 9 | Almost-full offset m, write-clock domain |
| offRdData | output | 9 | Offset readback word |
| offRdValid | output | 1 | Readback word valid for one read cycle |
| accessErr | output | 1 | Sticky flag for a read that coincided with a write |

## Verification
A load write on the write clock and a load readback on the read clock can fall on the same edge. When they do, both operations touch the same register file, and the error flag sees both strobes at once. The bench runs the two clocks in a 2:3 ratio so that their rising edges line up once every frame. It triggers the collision by asserting the write and read strobes together, spanning exactly one shared edge, after both pointers have been reset onto the same register. It judges the result in three ways: the returned word must be the pre-write default, the delivered offset must carry the new value, and the error flag must rise and stay set through later accesses.

// File: rtl/flag_offset_pkg.sv
`timescale 1ns/100ps
package flag_offset_pkg;

  // Selection order: bit 1 picks the offset (0 empty, 1 full), bit 0 picks high part
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } offSel_t;

  typedef struct packed {
    logic    wrStb;     // store dataIn into wrSel
    offSel_t wrSel;
    logic    snapLoad;  // capture empty offset for transfer
  } wrStrobe_t;

  typedef struct packed {
    logic    rdStb;     // load readback word from rdSel
    offSel_t rdSel;
    logic    pubLoad;   // publish transferred empty offset
  } rdStrobe_t;

  function automatic offSel_t nextSel(offSel_t s);
    return offSel_t'(s + 2'd1);
  endfunction

endpackage

// File: rtl/flag_offset_ctrl.sv
`timescale 1ns/100ps
module flag_offset_ctrl
  import flag_offset_pkg::*;
(
  input  logic      wrClk,
  input  logic      rdClk,
  input  logic      rstN,
  input  logic      ldN,
  input  logic      wrEnN,
  input  logic      rdEnAN,
  input  logic      rdEnBN,
  output wrStrobe_t wrStrb,
  output rdStrobe_t rdStrb,
  output logic      offRdValid,
  output logic      accessErr
);

  // ---------------- write-clock side ----------------
  logic    progModeW;
  offSel_t wrPtr;
  logic    loadWr;
  logic    dirty;
  logic    reqTgl;
  logic    ackS1, ackS2;
  logic    hsBusy;
  logic    ackTgl;

  assign loadWr = progModeW && !ldN && !wrEnN;
  assign hsBusy = (reqTgl != ackS2);

  always_comb begin
    wrStrb.wrStb    = loadWr;
    wrStrb.wrSel    = wrPtr;
    wrStrb.snapLoad = dirty && !hsBusy;
  end

  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      progModeW <= !ldN;
      wrPtr     <= SEL_E_LO;
      dirty     <= 1'b0;
      reqTgl    <= 1'b0;
      ackS1     <= 1'b0;
      ackS2     <= 1'b0;
    end else begin
      ackS1 <= ackTgl;
      ackS2 <= ackS1;
      if (loadWr) wrPtr <= nextSel(wrPtr);
      if (wrStrb.snapLoad) begin
        reqTgl <= !reqTgl;
        dirty  <= loadWr;      // a write on the same edge needs another transfer
      end else if (loadWr) begin
        dirty  <= 1'b1;
      end
    end
  end

  // ---------------- read-clock side ----------------
  logic    progModeR;
  offSel_t rdPtr;
  logic    rdAcc;
  logic    reqS1, reqS2;

  assign rdAcc = progModeR && !ldN && !rdEnAN && !rdEnBN;

  always_comb begin
    rdStrb.rdStb   = rdAcc;
    rdStrb.rdSel   = rdPtr;
    rdStrb.pubLoad = (reqS2 != ackTgl);
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      progModeR  <= !ldN;
      rdPtr      <= SEL_E_LO;
      reqS1      <= 1'b0;
      reqS2      <= 1'b0;
      ackTgl     <= 1'b0;
      offRdValid <= 1'b0;
      accessErr  <= 1'b0;
    end else begin
      reqS1      <= reqTgl;
      reqS2      <= reqS1;
      if (rdStrb.pubLoad) ackTgl <= !ackTgl;
      offRdValid <= rdAcc;
      if (rdAcc) rdPtr <= nextSel(rdPtr);
      if (rdAcc && !wrEnN) accessErr <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  // R3: pointer holds whenever no load write is presented
  a_r3_wrptr_hold: assert property (@(posedge wrClk) disable iff (!rstN)
    (ldN || wrEnN) |=> $stable(wrPtr));

  // R10: read pointer holds when any read gate is inactive
  a_r10_rdptr_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    (ldN || rdEnAN || rdEnBN) |=> $stable(rdPtr));

  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge rdClk) disable iff (!rstN)
    accessErr |=> accessErr);

  // R8: no readback when load mode was not chosen
  a_r8_off_no_valid: assert property (@(posedge rdClk) disable iff (!rstN)
    !progModeR |=> !offRdValid);

  // R6: no new request while a transfer is outstanding
  a_r6_one_req: assert property (@(posedge wrClk) disable iff (!rstN)
    hsBusy |=> $stable(reqTgl));

endmodule

// File: rtl/flag_offset_regs.sv
`timescale 1ns/100ps
module flag_offset_regs
  import flag_offset_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int OFF_W   = 9,
  parameter int LO_W    = 8,
  parameter int DEF_OFF = 7
)(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  wrStrobe_t         wrStrb,
  input  rdStrobe_t         rdStrb,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset,
  output logic [DATA_W-1:0] offRdData
);

  localparam int HI_W = OFF_W - LO_W;
  localparam logic [OFF_W-1:0] DEF = OFF_W'(DEF_OFF);
  localparam int N_OFF = 2;

  logic [LO_W-1:0]  loQ  [N_OFF];
  logic [HI_W-1:0]  hiQ  [N_OFF];
  logic [OFF_W-1:0] offVal [N_OFF];
  logic [1:0]       wrSelBits, rdSelBits;
  logic [DATA_W-1:0] rdMux;
  logic [OFF_W-1:0] snapQ;
  logic             unusedDataBits;

  assign wrSelBits      = wrStrb.wrSel;
  assign rdSelBits      = rdStrb.rdSel;
  assign unusedDataBits = ^dataIn;

  // One low/high register pair per offset: index 0 empty, index 1 full
  for (genvar g = 0; g < N_OFF; g++) begin : g_off
    always_ff @(posedge wrClk) begin
      if (!rstN) begin
        loQ[g] <= DEF[LO_W-1:0];
        hiQ[g] <= DEF[OFF_W-1:LO_W];
      end else if (wrStrb.wrStb && (wrSelBits[1] == 1'(g))) begin
        if (wrSelBits[0]) hiQ[g] <= dataIn[HI_W-1:0];
        else              loQ[g] <= dataIn[LO_W-1:0];
      end
    end
    assign offVal[g] = {hiQ[g], loQ[g]};
  end

  assign fullOffset = offVal[1];

  // Readback word: low byte in low bits, high part right-aligned
  always_comb begin
    if (rdSelBits[0]) rdMux = DATA_W'(hiQ[rdSelBits[1]]);
    else              rdMux = DATA_W'(loQ[rdSelBits[1]]);
  end

  always_ff @(posedge rdClk) begin
    if (!rstN)              offRdData <= '0;
    else if (rdStrb.rdStb)  offRdData <= rdMux;
  end

  // Snapshot held stable in write domain while the request is in flight
  always_ff @(posedge wrClk) begin
    if (!rstN)                snapQ <= DEF;
    else if (wrStrb.snapLoad) snapQ <= offVal[0];
  end

  always_ff @(posedge rdClk) begin
    if (!rstN)               emptyOffset <= DEF;
    else if (rdStrb.pubLoad) emptyOffset <= snapQ;
  end

  // R6: read-side offset only moves on a delivered transfer
  a_r6_pub_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdStrb.pubLoad |=> $stable(emptyOffset));

  // R7: write-side offset only moves on a register store
  a_r7_full_hold: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrStrb.wrStb |=> $stable(fullOffset));

  // R10: readback word changes only on a read access
  a_r10_data_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdStrb.rdStb |=> $stable(offRdData));

endmodule

// File: rtl/flag_offset_seq.sv
`timescale 1ns/100ps
module flag_offset_seq
  import flag_offset_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 7,
  localparam int OFF_W  = $clog2(DEPTH),
  localparam int LO_W   = DATA_W - 1
)(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              wrEnN,
  input  logic              rdEnAN,
  input  logic              rdEnBN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset,
  output logic [DATA_W-1:0] offRdData,
  output logic              offRdValid,
  output logic              accessErr
);

  wrStrobe_t wrStrb;
  rdStrobe_t rdStrb;

  flag_offset_ctrl ctrl_i (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .ldN        (ldN),
    .wrEnN      (wrEnN),
    .rdEnAN     (rdEnAN),
    .rdEnBN     (rdEnBN),
    .wrStrb     (wrStrb),
    .rdStrb     (rdStrb),
    .offRdValid (offRdValid),
    .accessErr  (accessErr)
  );

  flag_offset_regs #(
    .DATA_W  (DATA_W),
    .OFF_W   (OFF_W),
    .LO_W    (LO_W),
    .DEF_OFF (DEF_OFF)
  ) regs_i (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .wrStrb      (wrStrb),
    .rdStrb      (rdStrb),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset),
    .offRdData   (offRdData)
  );

endmodule

// File: tb/flag_offset_seq_tb.sv
`timescale 1ns/100ps
module flag_offset_seq_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam real RD_PERIOD  = CLK_PERIOD * 1.5;
  localparam real FRAME      = CLK_PERIOD * 3.0;
  localparam real FRAME_OFS  = CLK_PERIOD / 2.0;

  logic       wrClk = 1'b0, rdClk = 1'b0;
  logic       rstN = 1'b0, ldN = 1'b1, wrEnN = 1'b1, rdEnAN = 1'b1, rdEnBN = 1'b1;
  logic [8:0] dataIn = '0;
  logic [8:0] emptyOffset, fullOffset, offRdData;
  logic       offRdValid, accessErr;

  int checks = 0;
  int failures = 0;
  int expReg [4];
  int wrIdx, rdIdx;

  flag_offset_seq dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .ldN(ldN), .wrEnN(wrEnN),
    .rdEnAN(rdEnAN), .rdEnBN(rdEnBN), .dataIn(dataIn),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .offRdData(offRdData), .offRdValid(offRdValid), .accessErr(accessErr)
  );

  // rising edges of both clocks coincide once per frame
  initial begin
    #(FRAME_OFS);
    forever begin wrClk = 1'b1; #(CLK_PERIOD/2.0); wrClk = 1'b0; #(CLK_PERIOD/2.0); end
  end
  initial begin
    #(FRAME_OFS);
    forever begin rdClk = 1'b1; #(RD_PERIOD/2.0); rdClk = 1'b0; #(RD_PERIOD/2.0); end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // go to 2 ns before the next shared edge
  task automatic toFrame();
    real r, nxt, d;
    r   = $realtime;
    nxt = FRAME_OFS + FRAME * ($floor((r - FRAME_OFS) / FRAME) + 1.0);
    d   = nxt - 2.0 - r;
    if (d <= 0.0) d = d + FRAME;
    #(d);
  endtask

  task automatic modelReset();
    expReg = '{7, 0, 7, 0};
    wrIdx = 0;
    rdIdx = 0;
  endtask

  task automatic modelWrite(int v);
    expReg[wrIdx] = (wrIdx % 2 == 0) ? (v & 255) : (v & 1);
    wrIdx = (wrIdx + 1) % 4;
  endtask

  function automatic int expN();
    return expReg[1] * 256 + expReg[0];
  endfunction
  function automatic int expM();
    return expReg[3] * 256 + expReg[2];
  endfunction

  task automatic doReset(bit loadMode);
    toFrame();
    rstN = 1'b0; ldN = loadMode ? 1'b0 : 1'b1;
    wrEnN = 1'b1; rdEnAN = 1'b1; rdEnBN = 1'b1;
    #(FRAME * 4.0);
    rstN = 1'b1; ldN = 1'b1;
    #3;
    modelReset();
  endtask

  // one load write on exactly one write edge; returns at frame+1
  task automatic loadWrite(int v);
    toFrame();
    ldN = 1'b0; wrEnN = 1'b0; dataIn = 9'(v);
    #3;
    ldN = 1'b1; wrEnN = 1'b1;
  endtask

  // one load read on exactly one read edge; samples at frame+3
  task automatic loadRead(output int data, output int valid);
    toFrame();
    ldN = 1'b0; rdEnAN = 1'b0; rdEnBN = 1'b0;
    #3;
    ldN = 1'b1; rdEnAN = 1'b1; rdEnBN = 1'b1;
    #2;
    data = int'(offRdData); valid = int'(offRdValid);
  endtask

  task automatic readExpect(string tag);
    int d, v;
    loadRead(d, v);
    chk({tag, " valid"}, v, 1);
    chk({tag, " data"}, d, expReg[rdIdx]);
    rdIdx = (rdIdx + 1) % 4;
  endtask

  task automatic settle();
    #(FRAME * 10.0);
  endtask

  initial begin : main
    int d, v;
    // ---- R1 reset state ----
    doReset(1'b1);
    chk("R1 emptyOffset", int'(emptyOffset), 7);
    chk("R1 fullOffset", int'(fullOffset), 7);
    chk("R1 offRdValid", int'(offRdValid), 0);
    chk("R1 accessErr", int'(accessErr), 0);
    // R4 read order and wrap over the defaults
    for (int i = 0; i < 5; i++) readExpect("R4 default readback");

    // ---- sweep over write values (R2 R5 R7 R6 R4) ----
    doReset(1'b1);
    for (int k = 0; k < 24; k++) begin
      for (int j = 0; j < 4; j++) begin
        int val;
        val = (k * 53 + j * 29 + 1) & 511;
        loadWrite(val);
        modelWrite(val);
        if (j >= 2) chk("R7 fullOffset after store", int'(fullOffset), expM());
      end
      settle();
      chk("R6 R5 emptyOffset delivered", int'(emptyOffset), expN());
      chk("R5 fullOffset composed", int'(fullOffset), expM());
      for (int j = 0; j < 4; j++) readExpect("R4 R2 sweep readback");
    end

    // ---- R3 pause keeps position, R2 wrap ----
    doReset(1'b1);
    loadWrite(9'h0A5); modelWrite(9'h0A5);
    loadWrite(9'h1FF); modelWrite(9'h1FF);
    settle();
    chk("R3 emptyOffset after partial", int'(emptyOffset), 256 + 165);
    loadWrite(9'h033); modelWrite(9'h033);
    chk("R3 continues at full-low", int'(fullOffset), 16'h033);
    loadWrite(9'h001); modelWrite(9'h001);
    chk("R3 full-high next", int'(fullOffset), 256 + 16'h033);
    loadWrite(9'h012); modelWrite(9'h012);
    settle();
    chk("R2 fifth write wraps to empty-low", int'(emptyOffset), 256 + 18);
    chk("R2 full unchanged by wrap", int'(fullOffset), 256 + 51);

    // ---- R10 gating of reads ----
    readExpect("R10 first read");
    d = int'(offRdData);
    toFrame();
    ldN = 1'b0; rdEnAN = 1'b0; rdEnBN = 1'b1;
    #3; ldN = 1'b1; rdEnAN = 1'b1; #2;
    chk("R10 one enable high no valid", int'(offRdValid), 0);
    chk("R10 data held", int'(offRdData), d);
    toFrame();
    ldN = 1'b1; rdEnAN = 1'b0; rdEnBN = 1'b0;
    #3; rdEnAN = 1'b1; rdEnBN = 1'b1; #2;
    chk("R10 ldN high no valid", int'(offRdValid), 0);
    readExpect("R10 pointer not advanced");
    #(CLK_PERIOD * 1.5);
    chk("R10 valid single cycle", int'(offRdValid), 0);

    // ---- R9 collision ----
    doReset(1'b1);
    toFrame();
    ldN = 1'b0; wrEnN = 1'b0; rdEnAN = 1'b0; rdEnBN = 1'b0; dataIn = 9'h1AB;
    #3;
    ldN = 1'b1; wrEnN = 1'b1; rdEnAN = 1'b1; rdEnBN = 1'b1;
    #2;
    chk("R9 read returns old value", int'(offRdData), 7);
    chk("R9 error raised", int'(accessErr), 1);
    modelWrite(9'h1AB);
    rdIdx = 1;
    settle();
    chk("R9 write took effect", int'(emptyOffset), 16'hAB);
    readExpect("R9 read after collision");
    chk("R9 error sticky", int'(accessErr), 1);
    doReset(1'b1);
    chk("R1 reset clears error", int'(accessErr), 0);

    // ---- R8 load mode off ----
    doReset(1'b0);
    loadWrite(9'h055);
    loadWrite(9'h001);
    loadWrite(9'h0CC);
    chk("R8 fullOffset unchanged", int'(fullOffset), 7);
    loadRead(d, v);
    chk("R8 no readback valid", v, 0);
    toFrame();
    ldN = 1'b0; wrEnN = 1'b0; rdEnAN = 1'b0; rdEnBN = 1'b0;
    #3; ldN = 1'b1; wrEnN = 1'b1; rdEnAN = 1'b1; rdEnBN = 1'b1; #2;
    chk("R8 no error when off", int'(accessErr), 0);
    settle();
    chk("R8 emptyOffset unchanged", int'(emptyOffset), 7);
    doReset(1'b1);
    loadWrite(9'h020); modelWrite(9'h020);
    settle();
    chk("R8 load mode back after reset", int'(emptyOffset), 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule